// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level translation structure held in ordinary memory. A request arrives on a valid/ready handshake and carries the address, a write flag and a user-mode flag. With translation switched on, the walker reads one directory entry and then one table entry over a single-outstanding memory port. It checks presence and access rights against both entries. If the access is legal, it writes back the entries whose accessed or dirty flags must change. Each accepted request ends with a one-cycle `rsp_done` pulse. That pulse carries either the physical address or a fault with a three-bit cause and the faulting linear address.

Entry layout, used by both levels: bit 0 means present, bit 1 means writable, bit 2 means user-accessible, bit 5 is the accessed flag and bit 6 is the dirty flag. The upper 20 bits hold a 4 KB-aligned frame number. The directory index is taken from linear bits 31:22, the table index from bits 21:12, and the byte offset from bits 11:0. Every other entry bit is carried through untouched.

Top module: `pt_walker`

## Requirements
- R1: When `cfg_paging_en` is 0 at acceptance, the walker makes no memory access, and `rsp_paddr` equals `req_laddr` with `rsp_fault` = 0.
- R2: The directory entry is read from `{cfg_dir_pfn, laddr[31:22], 2'b00}`. The table entry is read next, from `{dir_entry[31:12], laddr[21:12], 2'b00}`.
- R3: On success, `rsp_paddr` = `{table_entry[31:12], laddr[11:0]}`.
- R4: If bit 0 is clear in the directory entry, or in the table entry, the request faults with cause bit 0 = 0. The table entry is not read when the directory entry is absent.
- R5: The effective user-access right is the AND of bit 2 of both entries. A user request without that right faults with cause bit 0 = 1. A supervisor request is never refused for this reason.
- R6: The effective write right is the AND of bit 1 of both entries. A write without that right faults with cause bit 0 = 1 if the request is from user mode, or if `cfg_wp` = 1. A supervisor write without the right succeeds when `cfg_wp` = 0.
- R7: After a successful walk, bit 5 is set in both entries in memory. Bit 6 is also set in the table entry when the request was a write. No bit is ever cleared, and all other bits stay unchanged.
- R8: An entry is written back only when its value changes. A faulting request makes no memory write at all.
- R9: `req_ready` is high only while idle. Each accepted request gives exactly one `rsp_done` pulse. On a fault, cause bit 1 equals the write flag, cause bit 2 equals the user flag, and `rsp_fault_addr` equals the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken when valid |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user mode |
| cfg_dir_pfn | input | 20 | Frame number of the directory |
| cfg_paging_en | input | 1 | Translation enable |
| cfg_wp | input | 1 | Apply read-only pages to supervisor writes |
| mem_req | output | 1 | Memory access pending, held until acknowledged |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry value |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 3 | {user, write, rights violation} |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault_addr | output | 32 | Linear address that faulted |

## Verification
The interesting overlap is the first write to a fresh page: the accessed and dirty flags of the table entry must both change in a single store. The same walk may also have to update the directory's accessed flag. The bench provokes this with user and supervisor writes to entries whose bits 5 and 6 are clear, including supervisor writes to read-only pages under `cfg_wp` = 0. It judges the result by the number of memory writes seen during the request and by the final words in its memory model, both compared with its own walk of the tables. Faults are judged the same way: the entries must be unchanged and no write may appear.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENT_P   = 0;
  localparam int ENT_RW  = 1;
  localparam int ENT_US  = 2;
  localparam int ENT_ACC = 5;
  localparam int ENT_DRT = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_DIR,
    S_RD_TBL,
    S_WB_DIR,
    S_WB_TBL
  } ptw_state_e;
endpackage

// File: rtl/ptw_rights.sv
module ptw_rights (
  input  logic dir_rw,
  input  logic dir_us,
  input  logic tbl_rw,
  input  logic tbl_us,
  input  logic is_write,
  input  logic is_user,
  input  logic wp,
  output logic allow
);
  logic us_ok, rw_ok, us_bad, rw_bad;

  always_comb begin
    us_ok  = dir_us & tbl_us;
    rw_ok  = dir_rw & tbl_rw;
    us_bad = is_user & ~us_ok;
    rw_bad = is_write & ~rw_ok & (is_user | wp);
    allow  = ~us_bad & ~rw_bad;
  end
endmodule

// File: rtl/ptw_flag_merge.sv
module ptw_flag_merge #(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent_in,
  input  logic             set_dirty,
  output logic [ENT_W-1:0] ent_out,
  output logic             changed
);
  import ptw_pkg::*;

  always_comb begin
    ent_out          = ent_in;
    ent_out[ENT_ACC] = 1'b1;
    if (set_dirty) ent_out[ENT_DRT] = 1'b1;
    changed          = (ent_out != ent_in);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_laddr,
  input  logic                    req_write,
  input  logic                    req_user,
  input  logic [ADDR_W-OFF_W-1:0] cfg_dir_pfn,
  input  logic                    cfg_paging_en,
  input  logic                    cfg_wp,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [ADDR_W-1:0]       mem_rdata,
  output logic                    rsp_done,
  output logic                    rsp_fault,
  output logic [2:0]              rsp_cause,
  output logic [ADDR_W-1:0]       rsp_paddr,
  output logic [ADDR_W-1:0]       rsp_fault_addr
);
  import ptw_pkg::*;

  localparam int PFN_W   = ADDR_W - OFF_W;
  localparam int IDX_W   = PFN_W / 2;
  localparam int ENT_LOG = OFF_W - IDX_W;
  localparam int DIR_LO  = OFF_W + IDX_W;

  ptw_state_e        state_q;
  logic [ADDR_W-1:0] laddr_q, pde_q, pte_q;
  logic [PFN_W-1:0]  root_q;
  logic              wr_q, user_q, wp_q;

  logic [ADDR_W-1:0] tbl_src, dir_new, tbl_new;
  logic              dir_chg, tbl_chg, allow;

  assign tbl_src = (state_q == S_RD_TBL) ? mem_rdata : pte_q;

  ptw_rights u_rights (
    .dir_rw   (pde_q[ENT_RW]),
    .dir_us   (pde_q[ENT_US]),
    .tbl_rw   (mem_rdata[ENT_RW]),
    .tbl_us   (mem_rdata[ENT_US]),
    .is_write (wr_q),
    .is_user  (user_q),
    .wp       (wp_q),
    .allow    (allow)
  );

  ptw_flag_merge #(.ENT_W(ADDR_W)) u_dir_merge (
    .ent_in    (pde_q),
    .set_dirty (1'b0),
    .ent_out   (dir_new),
    .changed   (dir_chg)
  );

  ptw_flag_merge #(.ENT_W(ADDR_W)) u_tbl_merge (
    .ent_in    (tbl_src),
    .set_dirty (wr_q),
    .ent_out   (tbl_new),
    .changed   (tbl_chg)
  );

  assign req_ready = (state_q == S_IDLE);
  assign mem_req   = (state_q != S_IDLE);
  assign mem_we    = (state_q == S_WB_DIR) || (state_q == S_WB_TBL);
  assign mem_wdata = (state_q == S_WB_DIR) ? dir_new : tbl_new;

  always_comb begin
    case (state_q)
      S_RD_DIR, S_WB_DIR:
        mem_addr = {root_q, laddr_q[ADDR_W-1:DIR_LO], {ENT_LOG{1'b0}}};
      S_RD_TBL, S_WB_TBL:
        mem_addr = {pde_q[ADDR_W-1:OFF_W], laddr_q[DIR_LO-1:OFF_W], {ENT_LOG{1'b0}}};
      default:
        mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= S_IDLE;
      laddr_q        <= '0;
      pde_q          <= '0;
      pte_q          <= '0;
      root_q         <= '0;
      wr_q           <= 1'b0;
      user_q         <= 1'b0;
      wp_q           <= 1'b0;
      rsp_done       <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_cause      <= '0;
      rsp_paddr      <= '0;
      rsp_fault_addr <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid) begin
          laddr_q <= req_laddr;
          wr_q    <= req_write;
          user_q  <= req_user;
          wp_q    <= cfg_wp;
          root_q  <= cfg_dir_pfn;
          if (cfg_paging_en) begin
            state_q <= S_RD_DIR;
          end else begin
            rsp_done  <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= req_laddr;
          end
        end
        S_RD_DIR: if (mem_ack) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[ENT_P]) begin
            state_q        <= S_IDLE;
            rsp_done       <= 1'b1;
            rsp_fault      <= 1'b1;
            rsp_cause      <= {user_q, wr_q, 1'b0};
            rsp_fault_addr <= laddr_q;
          end else begin
            state_q <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_ack) begin
          pte_q <= mem_rdata;
          if (!mem_rdata[ENT_P] || !allow) begin
            state_q        <= S_IDLE;
            rsp_done       <= 1'b1;
            rsp_fault      <= 1'b1;
            rsp_cause      <= {user_q, wr_q, mem_rdata[ENT_P]};
            rsp_fault_addr <= laddr_q;
          end else if (dir_chg) begin
            state_q <= S_WB_DIR;
          end else if (tbl_chg) begin
            state_q <= S_WB_TBL;
          end else begin
            state_q   <= S_IDLE;
            rsp_done  <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {mem_rdata[ADDR_W-1:OFF_W], laddr_q[OFF_W-1:0]};
          end
        end
        S_WB_DIR: if (mem_ack) begin
          if (tbl_chg) begin
            state_q <= S_WB_TBL;
          end else begin
            state_q   <= S_IDLE;
            rsp_done  <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {pte_q[ADDR_W-1:OFF_W], laddr_q[OFF_W-1:0]};
          end
        end
        S_WB_TBL: if (mem_ack) begin
          state_q   <= S_IDLE;
          rsp_done  <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_paddr <= {pte_q[ADDR_W-1:OFF_W], laddr_q[OFF_W-1:0]};
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2: an access stays stable until the memory acknowledges it
  a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: a write-back only adds the accessed/dirty flags to the entry it read
  a_r7_flags_only_set: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |->
      ((mem_wdata ^ ((state_q == S_WB_DIR) ? pde_q : pte_q)) & ~(ADDR_W'(32'h60))) == '0 &&
      ((((state_q == S_WB_DIR) ? pde_q : pte_q) & ~mem_wdata) == '0));

  // R8: a write-back always changes the stored entry
  a_r8_wb_changes: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata != ((state_q == S_WB_DIR) ? pde_q : pte_q)));

  // R9: no memory traffic while a new request can be taken
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  // R3: a successful translation keeps the byte offset
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && !rsp_fault && $past(mem_req)) |-> (rsp_paddr[OFF_W-1:0] == laddr_q[OFF_W-1:0]));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_laddr = '0;
  logic [19:0] cfg_dir_pfn = 20'h00400;
  logic        cfg_paging_en = 1'b0, cfg_wp = 1'b0;
  logic        req_ready, mem_req, mem_we, mem_ack, rsp_done, rsp_fault;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rsp_paddr, rsp_fault_addr;
  logic [2:0]  rsp_cause;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_write(req_write), .req_user(req_user),
    .cfg_dir_pfn(cfg_dir_pfn), .cfg_paging_en(cfg_paging_en), .cfg_wp(cfg_wp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_fault_addr(rsp_fault_addr)
  );

  int unsigned n_chk = 0, n_bad = 0;
  int          acc_cnt = 0, wr_cnt = 0, b_acc = 0, b_wr = 0, n_done = 0, lat = 0;
  bit          finished = 0;
  logic [31:0] mem [logic [29:0]];
  logic [31:0] alog [int];

  typedef struct {
    logic        f;
    logic [2:0]  c;
    logic [31:0] a;
    int          na;
    int          nw;
    logic        pg;
  } exp_t;
  exp_t  q_exp[$];
  string q_tag[$];

  function automatic logic [31:0] rdw(logic [31:0] a);
    return mem.exists(a[31:2]) ? mem[a[31:2]] : 32'h0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory model with variable latency
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      lat = 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (lat == 0) begin
          mem_ack <= 1'b1;
          lat = $urandom_range(2, 0);
          alog[acc_cnt] = mem_addr;
          acc_cnt++;
          if (mem_we) begin
            mem[mem_addr[31:2]] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata <= rdw(mem_addr);
          end
        end else begin
          lat--;
        end
      end
    end
  end

  // monitor: scoreboard compare on each completion
  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9 extra done actual=1 expected=0");
      end else begin
        exp_t  e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, "fault", {31'h0, rsp_fault}, {31'h0, e.f});
        if (e.f) begin
          chk(t, "cause", {29'h0, rsp_cause}, {29'h0, e.c});
          chk("R9", "fault addr", rsp_fault_addr, e.a);
        end else begin
          chk(t, "paddr", rsp_paddr, e.a);
        end
        chk(e.pg ? "R2" : "R1", "accesses", acc_cnt - b_acc, e.na);
        chk("R8", "writes", wr_cnt - b_wr, e.nw);
      end
      n_done++;
    end
  end

  task automatic txn(input logic [31:0] la, input logic w, input logic u,
                     input logic pg, input logic wp);
    exp_t        e;
    string       tag;
    logic [31:0] pa, ta, pde, pte, npde, npte;
    int          d0;
    pa = '0; ta = '0; pde = '0; pte = '0; npde = '0; npte = '0;
    e.f = 0; e.c = '0; e.a = la; e.na = 0; e.nw = 0; e.pg = pg;
    tag = "R1";
    if (pg) begin
      pa = {cfg_dir_pfn, la[31:22], 2'b00};
      pde = rdw(pa); e.na = 1;
      if (!pde[0]) begin
        e.f = 1; e.c = {u, w, 1'b0}; tag = "R4";
      end else begin
        ta = {pde[31:12], la[21:12], 2'b00};
        pte = rdw(ta); e.na = 2;
        if (!pte[0]) begin
          e.f = 1; e.c = {u, w, 1'b0}; tag = "R4";
        end else if ((u && !(pde[2] & pte[2])) ||
                     (w && !(pde[1] & pte[1]) && (u || wp))) begin
          e.f = 1; e.c = {u, w, 1'b1};
          tag = (u && !(pde[2] & pte[2])) ? "R5" : "R6";
        end else begin
          npde = pde | 32'h20;
          npte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
          if (npde != pde) e.nw++;
          if (npte != pte) e.nw++;
          e.na = 2 + e.nw;
          e.a = {pte[31:12], la[11:0]};
          tag = (w && !(pde[1] & pte[1])) ? "R6" : (u ? "R5" : "R3");
        end
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    b_acc = acc_cnt; b_wr = wr_cnt;
    q_exp.push_back(e); q_tag.push_back(tag);
    d0 = n_done;
    req_laddr = la; req_write = w; req_user = u; cfg_paging_en = pg; cfg_wp = wp;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (pg) chk("R9", "ready during walk", {31'h0, req_ready}, 32'h0);
    while (n_done == d0) @(negedge clk);
    if (pg && e.na >= 1) chk("R2", "dir entry addr", alog[b_acc], pa);
    if (pg && e.na >= 2) chk("R2", "table entry addr", alog[b_acc + 1], ta);
    if (pg && !e.f) begin
      chk("R7", "dir entry after", rdw(pa), npde);
      chk("R7", "table entry after", rdw(ta), npte);
    end else if (pg) begin
      chk("R8", "dir entry kept", rdw(pa), pde);
      if (e.na == 2) chk("R8", "table entry kept", rdw(ta), pte);
    end
  endtask

  function automatic logic [31:0] la_of(int d, int t, int off);
    return {d[9:0], t[9:0], off[11:0]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "reset ready", {31'h0, req_ready}, 32'h1);
    chk("R9", "reset done", {31'h0, rsp_done}, 32'h0);
    chk("R2", "reset mem_req", {31'h0, mem_req}, 32'h0);

    mem[32'h00400000 >> 2] = 32'h00800007;
    mem[32'h00400004 >> 2] = 32'h00801006;
    mem[32'h00800000 >> 2] = 32'hABCDE007;
    mem[32'h00800004 >> 2] = 32'h11111005;
    mem[32'h00800008 >> 2] = 32'h22222003;
    mem[32'h0080000C >> 2] = 32'h33333006;
    mem[32'h00800010 >> 2] = 32'h44444005;
    for (int d = 2; d < 10; d++) begin
      logic [31:0] ent;
      ent = 32'h00800000 + d * 32'h1000;
      ent = ent | ($urandom & 32'h26) | ((d < 8) ? 32'h1 : 32'h0);
      mem[(32'h00400000 >> 2) + d] = ent;
      for (int t = 0; t < 16; t++) begin
        logic [31:0] pt;
        pt = ($urandom & 32'hFFFFF000) | ($urandom & 32'h66);
        if ($urandom_range(99, 0) < 85) pt = pt | 32'h1;
        mem[((32'h00800000 + d * 32'h1000) >> 2) + t] = pt;
      end
    end

    txn(32'hDEADBEEF, 1, 1, 0, 1);          // R1 bypass
    txn(la_of(0, 0, 12'h123), 0, 1, 1, 0);  // R3 fresh page, two write-backs
    txn(la_of(0, 0, 12'h456), 0, 1, 1, 0);  // R8 nothing to update
    txn(la_of(0, 0, 12'h789), 1, 1, 1, 0);  // R7 dirty only
    txn(la_of(0, 1, 12'h010), 1, 1, 1, 0);  // R6 user write to read-only
    txn(la_of(0, 4, 12'h020), 1, 0, 1, 1);  // R6 supervisor blocked by wp
    txn(la_of(0, 1, 12'h030), 1, 0, 1, 0);  // R6 supervisor override, A+D at once
    txn(la_of(0, 2, 12'h040), 0, 1, 1, 0);  // R5 user to supervisor page
    txn(la_of(0, 2, 12'h050), 1, 0, 1, 1);  // R5 supervisor allowed
    txn(la_of(0, 3, 12'h060), 0, 0, 1, 0);  // R4 table entry absent
    txn(la_of(1, 0, 12'h070), 0, 0, 1, 0);  // R4 directory entry absent
    for (int i = 0; i < 400; i++) begin
      txn(la_of($urandom_range(9, 0), $urandom_range(15, 0), $urandom_range(4095, 0)),
          1'($urandom), 1'($urandom), ($urandom_range(9, 0) != 0), 1'($urandom));
    end
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=busy expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule